// File: doc/BRIEF.md
# Reliability-Adaptive Chase Test-Pattern Generator

This block sits in front of an algebraic hard-decision decoder in a soft-decision Chase receiver. It takes one frame of signed log-likelihood ratios (LLRs), one per cycle. From each LLR it forms a hard decision and a magnitude. It also keeps a sorted list of the `P_HI` least reliable positions while the frame streams in, so no second pass over the frame is needed.

Once the frame ends, the block spends one cycle choosing how many positions to flip. It compares the largest magnitude in the sorted list against a threshold. A frame whose weakest bits are still fairly reliable gets the reduced width. Any other frame gets the full width `P_HI`. The block then emits every flip combination of the chosen width, one candidate word per accepted handshake, to the downstream decoder. It holds off new input until the last candidate has been taken.

Top module: `chase_pattern_gen`

## Requirements
- R1: Bit j of every candidate word starts from the hard decision of the j-th received LLR of the frame (the first beat is bit 0). The hard decision is 1 when the LLR is negative and 0 otherwise.
- R2: The block ranks the `P_HI` positions with the smallest magnitudes, with rank 0 for the smallest. When two magnitudes are equal, the position received earlier gets the lower rank.
- R3: The metric is the magnitude at rank `P_HI-1`. If the metric is greater than or equal to the threshold, the frame uses the reduced width and `out_wide` is 0. Otherwise it uses `P_HI` and `out_wide` is 1. `out_width` reports the width in use during every candidate of the frame.
- R4: For width P the block emits exactly 2^P candidates, with flip patterns 0, 1, … 2^P−1 in counting order. Bit k of the pattern inverts the position at rank k. The first candidate is therefore the unflipped hard-decision word. `out_last` is 1 only on the final candidate.
- R5: The most negative LLR code is saturated to the largest positive magnitude (2^(LLR_W−1)−1) before ranking.
- R6: `cfg_thresh` and `cfg_p_lo` are sampled on the first beat of a frame. Changes made later in the frame have no effect on that frame.
- R7: A `cfg_p_lo` value above `P_HI` is treated as `P_HI`.
- R8: `in_ready` is 1 only while the block accepts LLRs. After the beat carrying `in_last` there is one cycle with both `in_ready` and `out_valid` low. Candidates start on the next cycle, and `in_ready` and `out_valid` are never high together.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_word`, `out_last` and `out_width` hold their values.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | LLR beat valid |
| in_llr | input | LLR_W | Two's-complement LLR |
| in_last | input | 1 | Final beat of the frame |
| in_ready | output | 1 | Block accepts an LLR beat |
| cfg_thresh | input | LLR_W-1 | Width-selection threshold |
| cfg_p_lo | input | clog2(P_HI+1) | Reduced flip width |
| out_valid | output | 1 | Candidate word valid |
| out_ready | input | 1 | Downstream takes the candidate |
| out_word | output | N_POS | Candidate word |
| out_last | output | 1 | Final candidate of the frame |
| out_wide | output | 1 | 1 when the full width is in use |
| out_width | output | clog2(P_HI+1) | Flip width in use |

## Verification
One pseudo-random frame is run against every threshold value. This finds the exact boundary where the metric comparison switches widths. Every reduced-width code is also swept, including codes above `P_HI`, to separate the clamp from the counting order.

Three hand-built frames cover the ranking details. One of all-equal magnitudes tests tie ranking. One mixes saturated and near-full-scale values, so a wrapped magnitude would reorder the ranks. One changes the configuration during the frame. Random frames under steady, alternating and sparse `out_ready` patterns separate correct holding of a candidate from skipping or repeating it.

// File: rtl/chase_pkg.sv
package chase_pkg;

    typedef enum logic [1:0] {
        PH_IN     = 2'd0,
        PH_DECIDE = 2'd1,
        PH_EMIT   = 2'd2
    } phase_e;

endpackage

// File: rtl/chase_rank_list.sv
module chase_rank_list #(
    parameter int N_POS = 32,
    parameter int LLR_W = 6,
    parameter int P_HI  = 4,
    localparam int MAG_W = LLR_W - 1,
    localparam int IDX_W = $clog2(N_POS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr_i,
    input  logic                              ins_en_i,
    input  logic [MAG_W-1:0]                  ins_mag_i,
    input  logic [IDX_W-1:0]                  ins_idx_i,
    output logic [P_HI-1:0]                   ent_vld_o,
    output logic [P_HI-1:0][MAG_W-1:0]        ent_mag_o,
    output logic [P_HI-1:0][IDX_W-1:0]        ent_idx_o
);

    typedef struct packed {
        logic [P_HI-1:0]             vld;
        logic [P_HI-1:0][MAG_W-1:0]  mag;
        logic [P_HI-1:0][IDX_W-1:0]  idx;
    } list_t;

    list_t list_q, list_d, base;
    logic [P_HI-1:0] goes_before;

    always_comb begin
        base = clr_i ? '0 : list_q;
        // strict compare: an equal magnitude arriving later ranks after
        for (int k = 0; k < P_HI; k++) begin
            goes_before[k] = !base.vld[k] || (ins_mag_i < base.mag[k]);
        end
        list_d = base;
        if (ins_en_i) begin
            if (goes_before[0]) begin
                list_d.vld[0] = 1'b1;
                list_d.mag[0] = ins_mag_i;
                list_d.idx[0] = ins_idx_i;
            end
            for (int k = 1; k < P_HI; k++) begin
                if (goes_before[k]) begin
                    if (!goes_before[k-1]) begin
                        list_d.vld[k] = 1'b1;
                        list_d.mag[k] = ins_mag_i;
                        list_d.idx[k] = ins_idx_i;
                    end else begin
                        list_d.vld[k] = base.vld[k-1];
                        list_d.mag[k] = base.mag[k-1];
                        list_d.idx[k] = base.idx[k-1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) list_q <= '0;
        else        list_q <= list_d;
    end

    assign ent_vld_o = list_q.vld;
    assign ent_mag_o = list_q.mag;
    assign ent_idx_o = list_q.idx;

endmodule

// File: rtl/chase_width_sel.sv
module chase_width_sel #(
    parameter int MAG_W = 5,
    parameter int PW_W  = 3,
    parameter int P_HI  = 4
) (
    input  logic             tail_vld_i,
    input  logic [MAG_W-1:0] tail_mag_i,
    input  logic [MAG_W-1:0] thr_i,
    input  logic [PW_W-1:0]  p_lo_i,
    output logic             wide_o,
    output logic [PW_W-1:0]  width_o
);

    // single comparator on the weakest-but-P_HI magnitude
    always_comb begin
        wide_o  = !(tail_vld_i && (tail_mag_i >= thr_i));
        width_o = wide_o ? PW_W'(P_HI) : p_lo_i;
    end

endmodule

// File: rtl/chase_flip_mask.sv
module chase_flip_mask #(
    parameter int N_POS = 32,
    parameter int P_HI  = 4,
    localparam int IDX_W = $clog2(N_POS),
    localparam int PW_W  = $clog2(P_HI + 1)
) (
    input  logic [P_HI-1:0]             ent_vld_i,
    input  logic [P_HI-1:0][IDX_W-1:0]  ent_idx_i,
    input  logic [P_HI-1:0]             pat_i,
    input  logic [PW_W-1:0]             width_i,
    output logic [N_POS-1:0]            mask_o
);

    logic [P_HI-1:0][N_POS-1:0] rank_mask;

    for (genvar k = 0; k < P_HI; k++) begin : g_rank
        logic active;
        assign active       = pat_i[k] && ent_vld_i[k] && (width_i > PW_W'(k));
        assign rank_mask[k] = active ? (N_POS'(1) << ent_idx_i[k]) : '0;
    end

    always_comb begin
        mask_o = '0;
        for (int k = 0; k < P_HI; k++) begin
            mask_o = mask_o | rank_mask[k];
        end
    end

endmodule

// File: rtl/chase_pattern_gen.sv
module chase_pattern_gen #(
    parameter int N_POS = 32,
    parameter int LLR_W = 6,
    parameter int P_HI  = 4,
    localparam int MAG_W = LLR_W - 1,
    localparam int IDX_W = $clog2(N_POS),
    localparam int PW_W  = $clog2(P_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LLR_W-1:0]  in_llr,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [MAG_W-1:0]  cfg_thresh,
    input  logic [PW_W-1:0]   cfg_p_lo,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [N_POS-1:0]  out_word,
    output logic              out_last,
    output logic              out_wide,
    output logic [PW_W-1:0]   out_width
);
    import chase_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [N_POS-1:0]  hard;
        logic [MAG_W-1:0]  thr;
        logic [PW_W-1:0]   plo;
        logic              wide;
        logic [PW_W-1:0]   width;
        logic [P_HI-1:0]   pat;
    } st_t;

    st_t s_q, s_d;

    logic                        accept, frame_start, frame_end;
    logic [LLR_W-1:0]            neg_llr;
    logic [MAG_W-1:0]            in_mag;
    logic [PW_W-1:0]             plo_eff;
    logic [P_HI-1:0]             ent_vld;
    logic [P_HI-1:0][MAG_W-1:0]  ent_mag;
    logic [P_HI-1:0][IDX_W-1:0]  ent_idx;
    logic                        sel_wide;
    logic [PW_W-1:0]             sel_width;
    logic [N_POS-1:0]            flip_mask;
    logic [P_HI:0]               pat_span;
    logic                        emit_last;

    assign in_ready    = (s_q.phase == PH_IN);
    assign accept      = in_valid && in_ready;
    assign frame_start = (s_q.idx == '0);
    assign frame_end   = in_last || (s_q.idx == IDX_W'(N_POS - 1));

    // magnitude with saturation of the most negative code
    always_comb begin
        neg_llr = -in_llr;
        if (in_llr == {1'b1, {(LLR_W-1){1'b0}}}) in_mag = '1;
        else if (in_llr[LLR_W-1])                 in_mag = neg_llr[MAG_W-1:0];
        else                                      in_mag = in_llr[MAG_W-1:0];
        plo_eff = (cfg_p_lo > PW_W'(P_HI)) ? PW_W'(P_HI) : cfg_p_lo;
    end

    chase_rank_list #(.N_POS(N_POS), .LLR_W(LLR_W), .P_HI(P_HI)) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept && frame_start),
        .ins_en_i  (accept),
        .ins_mag_i (in_mag),
        .ins_idx_i (s_q.idx),
        .ent_vld_o (ent_vld),
        .ent_mag_o (ent_mag),
        .ent_idx_o (ent_idx)
    );

    chase_width_sel #(.MAG_W(MAG_W), .PW_W(PW_W), .P_HI(P_HI)) u_sel (
        .tail_vld_i (ent_vld[P_HI-1]),
        .tail_mag_i (ent_mag[P_HI-1]),
        .thr_i      (s_q.thr),
        .p_lo_i     (s_q.plo),
        .wide_o     (sel_wide),
        .width_o    (sel_width)
    );

    chase_flip_mask #(.N_POS(N_POS), .P_HI(P_HI)) u_mask (
        .ent_vld_i (ent_vld),
        .ent_idx_i (ent_idx),
        .pat_i     (s_q.pat),
        .width_i   (s_q.width),
        .mask_o    (flip_mask)
    );

    assign pat_span  = ((P_HI+1)'(1) << s_q.width) - (P_HI+1)'(1);
    assign emit_last = ({1'b0, s_q.pat} == pat_span);

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IN: begin
                if (accept) begin
                    if (frame_start) begin
                        s_d.hard = '0;
                        s_d.thr  = cfg_thresh;
                        s_d.plo  = plo_eff;
                    end
                    s_d.hard[s_q.idx] = in_llr[LLR_W-1];
                    if (frame_end) begin
                        s_d.phase = PH_DECIDE;
                        s_d.idx   = '0;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            PH_DECIDE: begin
                s_d.wide  = sel_wide;
                s_d.width = sel_width;
                s_d.pat   = '0;
                s_d.phase = PH_EMIT;
            end
            PH_EMIT: begin
                if (out_ready) begin
                    if (emit_last) s_d.phase = PH_IN;
                    else           s_d.pat   = s_q.pat + P_HI'(1);
                end
            end
            default: s_d.phase = PH_IN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = (s_q.phase == PH_EMIT);
    assign out_word  = s_q.hard ^ flip_mask;
    assign out_last  = out_valid && emit_last;
    assign out_wide  = s_q.wide;
    assign out_width = s_q.width;

endmodule

// File: rtl/chase_pattern_gen_chk.sv
module chase_pattern_gen_chk #(
    parameter int N_POS = 32,
    parameter int P_HI  = 4,
    parameter int PW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [N_POS-1:0]  out_word,
    input logic              out_last,
    input logic              out_wide,
    input logic [PW_W-1:0]   out_width
);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready && !out_valid);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(out_ready && out_last) |=> out_valid && !in_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_word) && $stable(out_last) && $stable(out_width));

    p_width_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wide ? (out_width == PW_W'(P_HI)) : (out_width <= PW_W'(P_HI))));

    p_width_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> $stable(out_width) && $stable(out_wide));

    p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready);

endmodule

bind chase_pattern_gen chase_pattern_gen_chk #(
    .N_POS (N_POS),
    .P_HI  (P_HI),
    .PW_W  (PW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_last  (out_last),
    .out_wide  (out_wide),
    .out_width (out_width)
);

// File: tb/chase_pattern_gen_tb.sv
module chase_pattern_gen_tb;
    localparam int N = 32;
    localparam int PH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [5:0] in_llr = '0;
    logic in_last = 1'b0;
    logic in_ready;
    logic [4:0] cfg_thresh = '0;
    logic [2:0] cfg_p_lo = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [N-1:0] out_word;
    logic out_last, out_wide;
    logic [2:0] out_width;

    int checks = 0;
    int fails = 0;
    int fr[N];
    logic [31:0] seed = 32'h1234_5678;

    logic [N-1:0] e_hard;
    int e_rank[PH];
    int e_metric, e_width;
    bit e_wide;

    always #10 clk = ~clk;

    chase_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
        .in_last(in_last), .in_ready(in_ready), .cfg_thresh(cfg_thresh),
        .cfg_p_lo(cfg_p_lo), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last), .out_wide(out_wide),
        .out_width(out_width)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int mag_of(input int v);
        if (v == -32) return 31;
        return (v < 0) ? -v : v;
    endfunction

    task automatic model(input int thr, input int plo);
        bit used[N];
        for (int j = 0; j < N; j++) begin
            e_hard[j] = (fr[j] < 0);
            used[j] = 0;
        end
        for (int r = 0; r < PH; r++) begin
            int best = -1;
            for (int j = 0; j < N; j++)
                if (!used[j] && (best < 0 || mag_of(fr[j]) < mag_of(fr[best]))) best = j;
            used[best] = 1;
            e_rank[r] = best;
        end
        e_metric = mag_of(fr[e_rank[PH-1]]);
        e_wide = (e_metric < thr);
        e_width = e_wide ? PH : ((plo > PH) ? PH : plo);
    endtask

    function automatic logic [N-1:0] cand(input int c);
        logic [N-1:0] w = e_hard;
        for (int k = 0; k < e_width; k++)
            if ((c >> k) & 1) w[e_rank[k]] = ~w[e_rank[k]];
        return w;
    endfunction

    task automatic rand_frame();
        for (int j = 0; j < N; j++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            fr[j] = int'(seed[21:16]) - 32;
        end
    endtask

    // bp: 0 always ready, 1 alternate, 2 one in three
    task automatic run_frame(input int thr, input int plo, input int bp, input bit midchg, input string tag);
        int c = 0;
        int cyc = 0;
        bit rdy;
        model(thr, plo);
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            if (j == 0) begin
                cfg_thresh = 5'(thr);
                cfg_p_lo = 3'(plo);
                chk(in_ready == 1'b1, "R8 in_ready idle", in_ready, 1);
            end
            if (j == 1 && midchg) begin
                cfg_thresh = 5'(thr == 0 ? 31 : 0);
                cfg_p_lo = 3'(plo == 1 ? 2 : 1);
            end
            in_valid = 1'b1;
            in_llr = fr[j][5:0];
            in_last = (j == N - 1);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        chk(!in_ready && !out_valid, "R8 decide gap", {in_ready, out_valid}, 0);
        @(posedge clk);
        while (c < (1 << e_width) && cyc < 400) begin
            @(negedge clk);
            rdy = (bp == 0) || (bp == 1 && cyc % 2 == 1) || (bp == 2 && cyc % 3 == 2);
            out_ready = rdy;
            chk(out_valid == 1'b1, {tag, " R8 out_valid"}, out_valid, 1);
            chk(in_ready == 1'b0, {tag, " R8 stall"}, in_ready, 0);
            chk(out_word == cand(c), {tag, " R1 R2 R4 R5 word"}, out_word, cand(c));
            if (rdy) begin
                chk(out_last == (c == (1 << e_width) - 1), {tag, " R4 last"}, out_last, (c == (1 << e_width) - 1));
                chk(out_width == 3'(e_width) && out_wide == e_wide, {tag, " R3 R6 R7 width"},
                    {out_wide, out_width}, {e_wide, 3'(e_width)});
                c++;
            end
            cyc++;
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready && !out_valid, {tag, " R4 frame done"}, {in_ready, out_valid}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 reset state", {in_ready, out_valid}, 2'b10);

        // R3: every threshold on one frame
        rand_frame();
        for (int t = 0; t < 32; t++) run_frame(t, 2, 0, 0, "R3 sweep");

        // R7 R4: every reduced-width code, forced low width
        rand_frame();
        for (int p = 0; p < 8; p++) run_frame(0, p, 0, 0, "R7 sweep");

        // R2: all equal magnitudes, alternating signs
        for (int j = 0; j < N; j++) fr[j] = (j % 2) ? -5 : 5;
        run_frame(31, 2, 0, 0, "R2 ties");
        run_frame(5, 1, 0, 0, "R2 ties low");

        // R5: saturation reorders ranks if mishandled
        for (int j = 0; j < N; j++) fr[j] = 31;
        fr[10] = -32; fr[20] = -32; fr[5] = 30; fr[25] = -30;
        run_frame(31, 2, 0, 0, "R5 sat");

        // R6: configuration changed mid-frame
        rand_frame();
        run_frame(31, 3, 0, 1, "R6 midchg");
        run_frame(0, 1, 0, 1, "R6 midchg b");

        // R9: backpressure with random frames
        for (int i = 0; i < 6; i++) begin
            rand_frame();
            run_frame(i * 5, i % 5, 1 + (i % 2), 0, "R9 bp");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule